// File: doc/BRIEF.md
# DMA protected range checker

This block guards a window of physical memory against device-initiated (DMA) accesses. Software programs a single 32-bit configuration word with three things. The first is a 1 MB-aligned top address: the first byte above the window. The second is a window size in megabytes. The third is an enable request. Hardware confirms the enable through a status bit a fixed number of cycles later. Until that confirmation arrives, the previous protection state keeps applying to requests. A lock bit freezes the configuration until reset.

Each DMA request carries a physical address that has already been translated. It also carries one deny verdict from each of several other protection units. The block checks the address against the window. It combines its own range hit with the external denies by OR. It returns a registered verdict with two bits: an allow bit, and a separate bit that says whether the range check caused the block.

The request side and the verdict side are both valid/ready streams. A request is taken on a cycle when `req_valid` and `req_ready` are both high. Its verdict appears with `res_valid` on the next cycle. The verdict stays unchanged for as long as `res_ready` is low. The block holds a single verdict, so `req_ready` is low exactly when a verdict is waiting and `res_ready` is low. The configuration port is a plain write strobe with a read value that always reflects the register.

Top module: `dma_guard`

## Requirements
- R1: Bits 31:20 of the configuration word hold the window top in MB units. The top byte address is that field shifted left by 20, with the lower 20 address bits zero. The field reads back as written.
- R2: Bits 11:4 hold the window size in MB. While protection status is active, an address whose MB index lies in [top − size, top − 1] is a range hit.
- R3: A size of zero produces no range hit, even when protection status is active.
- R4: Bit 2 is the software enable. Bit 1 is a read-only status that takes the enable value that was in force ACK_DLY cycles earlier. Range hits follow the status bit, not the enable bit.
- R5: The write is a violation when all of these hold: the block is unlocked, the write changes the enable bit, and enable still differs from status. On a violation, `cfg_err` pulses high for the one cycle after the write. The enable bit keeps its old value. The other fields still update.
- R6: Bit 0 is a lock. Once it reads 1, writes change no field, including the lock itself, until reset.
- R7: Bits 19:12 and bit 3 always read as zero, whatever is written.
- R8: `req_ready` is high unless a verdict is pending with `res_ready` low. An accepted request's verdict appears on the next cycle. The verdict is held stable while `res_ready` is low.
- R9: `res_allow` is 1 only when there is neither a range hit nor any asserted bit of `req_ext_deny`. `res_range_hit` reports the range hit alone.
- R10: If the size exceeds the top (both in MB), the window's lower bound is address zero rather than a wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| cfg_err | output | 1 | One-cycle pulse after an enable write that breaks the status rule |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | ADDR_W | Translated physical address |
| req_ext_deny | input | N_EXT | Deny verdicts from other protection units |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict ready |
| res_allow | output | 1 | Request may go to memory |
| res_range_hit | output | 1 | Request fell in the protected window |

## Verification
A wrong window bound or a wrong active state shows on `res_range_hit` and `res_allow` one cycle after the first request that touches the edge. For that reason the bench probes the addresses top − 1, top, top − size and top − size − 1, both inside and outside the status delay. A status pipeline that is too long or too short shows on `cfg_rdata` bit 1 in the cycle it should have toggled. A stale enable shows on `cfg_err` one cycle after the next conflicting write. Lock or reserved-bit faults show in `cfg_rdata` on the cycle after the offending write.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int TOP_W  = 12;
  localparam int SIZE_W = 8;
  localparam int MB_SH  = 20;

  localparam int TOP_LSB  = 20;
  localparam int SIZE_LSB = 4;
  localparam int EN_BIT   = 2;
  localparam int STS_BIT  = 1;
  localparam int LOCK_BIT = 0;

  typedef struct packed {
    logic [TOP_W-1:0]  top_mb;
    logic [SIZE_W-1:0] size_mb;
    logic              en;
    logic              sts;
    logic              lock;
  } dg_cfg_t;

  function automatic logic [31:0] dg_pack(input dg_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[TOP_LSB +: TOP_W]    = c.top_mb;
    w[SIZE_LSB +: SIZE_W]  = c.size_mb;
    w[EN_BIT]              = c.en;
    w[STS_BIT]             = c.sts;
    w[LOCK_BIT]            = c.lock;
    return w;
  endfunction
endpackage

// File: rtl/dg_sts_pipe.sv
module dg_sts_pipe #(
  parameter int ACK_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sts
);
  generate
    if (ACK_DLY <= 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts <= 1'b0;
        else        sts <= en;
      end
    end else begin : g_shift
      logic [ACK_DLY-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[ACK_DLY-2:0], en};
      end
      assign sts = stage[ACK_DLY-1];
    end
  endgenerate
endmodule

// File: rtl/dg_cfg_reg.sv
module dg_cfg_reg
  import dg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        sts,
  output dg_cfg_t     cfg,
  output logic        cfg_err
);
  logic [TOP_W-1:0]  top_q;
  logic [SIZE_W-1:0] size_q;
  logic              en_q;
  logic              lock_q;
  logic              wr_ok;
  logic              en_flip;
  logic              unsettled;
  logic              viol;

  assign wr_ok     = cfg_we && !lock_q;
  assign en_flip   = cfg_wdata[EN_BIT] != en_q;
  assign unsettled = en_q != sts;
  assign viol      = wr_ok && en_flip && unsettled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      size_q  <= '0;
      en_q    <= 1'b0;
      lock_q  <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= viol;
      if (wr_ok) begin
        top_q  <= cfg_wdata[TOP_LSB +: TOP_W];
        size_q <= cfg_wdata[SIZE_LSB +: SIZE_W];
        lock_q <= cfg_wdata[LOCK_BIT];
        if (!viol) en_q <= cfg_wdata[EN_BIT];
      end
    end
  end

  always_comb begin
    cfg.top_mb  = top_q;
    cfg.size_mb = size_q;
    cfg.en      = en_q;
    cfg.sts     = sts;
    cfg.lock    = lock_q;
  end
endmodule

// File: rtl/dg_window.sv
module dg_window
  import dg_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic [TOP_W-1:0]  top_mb,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int AMB_W = ADDR_W - MB_SH;

  logic [AMB_W-1:0] addr_mb;
  logic [TOP_W-1:0] lo_mb;
  logic [AMB_W-1:0] lo_ext;
  logic [AMB_W-1:0] top_ext;
  logic             size_gt;

  assign addr_mb = addr[ADDR_W-1:MB_SH];
  assign size_gt = TOP_W'(size_mb) > top_mb;
  assign lo_mb   = size_gt ? '0 : top_mb - TOP_W'(size_mb);
  assign lo_ext  = AMB_W'(lo_mb);
  assign top_ext = AMB_W'(top_mb);

  assign hit = active && (size_mb != '0) &&
               (addr_mb >= lo_ext) && (addr_mb < top_ext);
endmodule

// File: rtl/dg_verdict.sv
module dg_verdict #(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             range_hit,
  input  logic [N_EXT-1:0] ext_deny,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_allow,
  output logic             res_range_hit
);
  logic take;
  logic any_deny;

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;
  assign any_deny  = range_hit || (|ext_deny);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_allow     <= 1'b0;
      res_range_hit <= 1'b0;
    end else if (take) begin
      res_valid     <= 1'b1;
      res_allow     <= !any_deny;
      res_range_hit <= range_hit;
    end else if (res_ready) begin
      res_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_guard.sv
module dma_guard
  import dg_pkg::*;
#(
  parameter int ADDR_W  = 36,
  parameter int N_EXT   = 4,
  parameter int ACK_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_EXT-1:0]  req_ext_deny,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_allow,
  output logic              res_range_hit
);
  dg_cfg_t cfg;
  logic    sts;
  logic    hit;

  dg_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sts       (sts),
    .cfg       (cfg),
    .cfg_err   (cfg_err)
  );

  dg_sts_pipe #(.ACK_DLY(ACK_DLY)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg.en),
    .sts   (sts)
  );

  dg_window #(.ADDR_W(ADDR_W)) u_win (
    .top_mb  (cfg.top_mb),
    .size_mb (cfg.size_mb),
    .active  (cfg.sts),
    .addr    (req_addr),
    .hit     (hit)
  );

  dg_verdict #(.N_EXT(N_EXT)) u_vrd (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .range_hit     (hit),
    .ext_deny      (req_ext_deny),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_allow     (res_allow),
    .res_range_hit (res_range_hit)
  );

  assign cfg_rdata = dg_pack(cfg);
endmodule

// File: rtl/dma_guard_chk.sv
module dma_guard_chk #(
  parameter int ADDR_W = 36,
  parameter int N_EXT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_rdata,
  input logic              cfg_err,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [N_EXT-1:0]  req_ext_deny,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_allow,
  input logic              res_range_hit
);
  a_r8_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_allow) && $stable(res_range_hit));

  a_r9_hit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_range_hit |-> !res_allow);

  a_r9_ext_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_ext_deny != '0) |=> !res_allow);

  a_r6_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] |=> $stable({cfg_rdata[31:20], cfg_rdata[11:4], cfg_rdata[2], cfg_rdata[0]}));

  a_r5_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(cfg_rdata[2]));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[19:12] == 8'h00 && cfg_rdata[3] == 1'b0);
endmodule

bind dma_guard dma_guard_chk #(.ADDR_W(ADDR_W), .N_EXT(N_EXT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rdata     (cfg_rdata),
  .cfg_err       (cfg_err),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_ext_deny  (req_ext_deny),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_allow     (res_allow),
  .res_range_hit (res_range_hit)
);

// File: tb/dma_guard_tb.sv
`timescale 1ns/1ps
module dma_guard_tb;
  localparam int ADDR_W  = 36;
  localparam int N_EXT   = 4;
  localparam int ACK_DLY = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              cfg_err;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [N_EXT-1:0]  req_ext_deny = '0;
  logic              res_valid;
  logic              res_ready = 1'b1;
  logic              res_allow;
  logic              res_range_hit;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string win_tag = "R2";

  always #2 clk = ~clk;

  dma_guard #(.ADDR_W(ADDR_W), .N_EXT(N_EXT), .ACK_DLY(ACK_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_ext_deny(req_ext_deny),
    .res_valid(res_valid), .res_ready(res_ready), .res_allow(res_allow),
    .res_range_hit(res_range_hit)
  );

  // behavioural reference
  int m_top, m_size, m_en, m_sts, m_lock, m_err, m_rv, m_allow, m_hit;
  int en_q[$];

  task automatic m_reset();
    m_top = 0; m_size = 0; m_en = 0; m_sts = 0; m_lock = 0;
    m_err = 0; m_rv = 0; m_allow = 0; m_hit = 0;
    en_q = {};
    for (int i = 0; i < ACK_DLY - 1; i++) en_q.push_back(0);
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int amb, lo, h, acc, o_en, o_sts, e;
      acc = (req_valid && (!m_rv || res_ready)) ? 1 : 0;
      amb = int'(req_addr >> 20);
      lo  = (m_size > m_top) ? 0 : m_top - m_size;
      h   = (m_sts != 0 && m_size != 0 && amb >= lo && amb < m_top) ? 1 : 0;
      if (acc != 0) begin
        m_rv = 1; m_hit = h;
        m_allow = (h == 0 && req_ext_deny == '0) ? 1 : 0;
      end else if (res_ready) m_rv = 0;
      o_en = m_en; o_sts = m_sts;
      en_q.push_back(m_en);
      m_sts = en_q.pop_front();
      m_err = 0;
      if (cfg_we && m_lock == 0) begin
        e = (int'(cfg_wdata[2]) != o_en && o_en != o_sts) ? 1 : 0;
        m_top = int'(cfg_wdata[31:20]);
        m_size = int'(cfg_wdata[11:4]);
        m_lock = int'(cfg_wdata[0]);
        if (e == 0) m_en = int'(cfg_wdata[2]);
        m_err = e;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(int'(cfg_rdata[31:20]), m_top, "R1 top field");
      chk(int'(cfg_rdata[11:4]), m_size, "R2 size field");
      chk(int'({cfg_rdata[19:12], cfg_rdata[3]}), 0, "R7 reserved bits");
      chk(int'(cfg_rdata[2]), m_en, "R4 enable bit");
      chk(int'(cfg_rdata[1]), m_sts, "R4 status bit");
      chk(int'(cfg_rdata[0]), m_lock, "R6 lock bit");
      chk(int'(cfg_err), m_err, "R5 violation pulse");
      chk(int'(res_valid), m_rv, "R8 verdict valid");
      chk(int'(req_ready), (m_rv == 0 || res_ready) ? 1 : 0, "R8 request ready");
      if (m_rv != 0) begin
        chk(int'(res_allow), m_allow, "R9 allow");
        chk(int'(res_range_hit), m_hit, win_tag);
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int mb, input int off, input logic [N_EXT-1:0] ext);
    logic took;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = (ADDR_W'(mb) << 20) + ADDR_W'(off);
    req_ext_deny = ext;
    took = 1'b0;
    while (!took) begin
      #1 took = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0; req_ext_deny = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input int top, input int size, input int en, input int lock);
    return {12'(top), 8'hA5, 8'(size), 1'b1, 1'(en), 1'b1, 1'(lock)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(cfg_rdata), 0, "R1 reset word");
    chk(int'(res_valid), 0, "R8 reset valid");

    // R1 R7: program window top 256 MB, size 16 MB, enable; reserved bits set in data
    wr(word(256, 16, 1, 0));
    // R4: status still off, old state in force
    send(250, 0, '0);
    idle(ACK_DLY + 1);
    // R2 boundaries
    send(255, 32'hFFFFF, '0);
    send(256, 0, '0);
    send(240, 0, '0);
    send(239, 32'hFFFFF, '0);
    // R9 external deny only
    send(100, 0, 4'b0100);
    send(245, 0, 4'b0001);
    // R8 back-pressure
    @(negedge clk); res_ready = 1'b0;
    send(241, 0, '0);
    fork
      send(10, 0, '0);
      begin idle(3); res_ready = 1'b1; end
    join
    idle(2);
    // R3 zero size
    win_tag = "R3 zero size";
    wr(word(256, 0, 1, 0));
    send(255, 0, '0);
    send(0, 0, '0);
    // R10 saturation
    win_tag = "R10 saturated lower bound";
    wr(word(8, 20, 1, 0));
    send(0, 0, '0);
    send(7, 5, '0);
    send(8, 0, '0);
    win_tag = "R2";
    // R5 enable toggled before status caught up
    wr(word(8, 20, 0, 0));
    wr(word(8, 20, 1, 0));
    idle(ACK_DLY + 2);
    send(3, 0, '0);
    // R6 lock then attempted changes
    wr(word(300, 50, 1, 1));
    idle(ACK_DLY + 2);
    wr(word(5, 1, 0, 0));
    idle(2);
    chk(int'(cfg_rdata[31:20]), 300, "R6 top frozen");
    chk(int'(cfg_rdata[0]), 1, "R6 lock frozen");
    send(260, 0, '0);
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule